// File: doc/BRIEF.md
# Sequential-Load Input Gamma Table

This block holds a three-channel input gamma table with 256 entries per channel. Each entry is an unsigned 12-bit fraction: value v stands for v/4096. Software loads the table through a narrow programming interface. It first writes a start entry number into a pointer. It then pushes words one after another into a single data input. The first accepted word goes to the red channel of the entry the pointer selects, the second to green and the third to blue. After the blue word the pointer moves to the next entry on its own, so a full table takes one pointer write followed by 768 data words.

A 3-bit channel mask decides which of the three channel words actually reach storage. Words for masked-off channels still consume their slot in the red/green/blue rotation. A memory power control must be held on while loading. Data words offered while it is off are dropped completely.

On the pixel side, an 8-bit red, green and blue triplet indexes the three channel tables independently. The matching 12-bit fractions come out one clock later. Lookups are independent of loading. A lookup that reads an entry in the same cycle as it is being written returns the contents from before that write. The reset input is asynchronous active-low and is expected to be deasserted synchronously to the clock upstream.

Top module: `gamma_seq_lut`

## Requirements
- R1: Each channel stores 256 entries of 12-bit u0.12 values. A lookup returns on `out_r`, `out_g` and `out_b` the entries of the red, green and blue tables addressed by `pix_r`, `pix_g` and `pix_b` respectively.
- R2: `out_vld` is high exactly in the cycle after a cycle with `pix_vld` high, and the output values change only then. When `pix_vld` is low, `out_vld` drops and the output values hold.
- R3: A pointer write (`idx_wr` high) loads `idx_val` into the entry pointer and returns the channel rotation to red.
- R4: Accepted data words go to red, then green, then blue of the entry under the pointer. After the blue word the pointer increments by one and the rotation returns to red.
- R5: The pointer wraps from 255 to 0 after the blue word of entry 255.
- R6: `wr_mask` bit 0 enables storing red, bit 1 green and bit 2 blue (3'b111 enables all). A word whose channel bit is clear still advances the rotation but leaves the stored entry unchanged.
- R7: A data word offered while `lut_pwr_on` is low is ignored. Nothing is stored, and neither the rotation nor the pointer moves.
- R8: When `idx_wr` and `dat_wr` are high in the same cycle, the pointer write takes effect and the data word is dropped.
- R9: A lookup of an entry in the same cycle as a write to that entry returns the value stored before the write.
- R10: After reset, `out_vld` is 0, all three outputs are 0, the pointer is 0 and the rotation is at red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Pointer write strobe |
| idx_val | input | 8 | New entry pointer |
| dat_wr | input | 1 | Data word strobe |
| dat_val | input | 12 | Data word, u0.12 |
| wr_mask | input | 3 | Channel store enables: bit0 red, bit1 green, bit2 blue |
| lut_pwr_on | input | 1 | Table memory powered for loading |
| pix_vld | input | 1 | Lookup request |
| pix_r | input | 8 | Red index |
| pix_g | input | 8 | Green index |
| pix_b | input | 8 | Blue index |
| out_vld | output | 1 | Lookup result valid |
| out_r | output | 12 | Red result |
| out_g | output | 12 | Green result |
| out_b | output | 12 | Blue result |

## Verification
A lookup result is due at the first rising edge after the request is sampled, so it appears one cycle after `pix_vld`. A pointer or data write alters state at the edge that samples it, and its effect shows only in lookups issued in a later cycle. A same-cycle lookup must still return the old value. The bench changes inputs just after each falling edge and advances its behavioural model at the rising edge, reading old table contents before applying that edge's write. It then compares every output at the following falling edge, which is exactly where these latencies place the results.

// File: rtl/gamma_lut_pkg.sv
`timescale 1ns/1ps
package gamma_lut_pkg;
  localparam int unsigned NCH = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  function automatic logic [NCH-1:0] phase_sel(input phase_e p);
    logic [NCH-1:0] s;
    s = '0;
    s[p] = 1'b1;
    return s;
  endfunction

  function automatic phase_e phase_next(input phase_e p);
    phase_e n;
    case (p)
      PH_RED:  n = PH_GRN;
      PH_GRN:  n = PH_BLU;
      default: n = PH_RED;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/gamma_wr_seq.sv
`timescale 1ns/1ps
module gamma_wr_seq
  import gamma_lut_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             dat_wr,
  input  logic             pwr_on,
  input  logic [NCH-1:0]   wr_mask,
  output logic [NCH-1:0]   ch_we,
  output logic [IDX_W-1:0] ptr,
  output phase_e           phase
);
  localparam logic [IDX_W-1:0] PTR_ONE = IDX_W'(1);

  logic             accept;
  logic             ptr_en;
  logic [IDX_W-1:0] ptr_d;
  phase_e           phase_d;

  assign accept = dat_wr & pwr_on & ~idx_wr;
  assign ch_we  = accept ? (phase_sel(phase) & wr_mask) : '0;
  assign ptr_en = idx_wr | accept;

  always_comb begin
    ptr_d   = ptr;
    phase_d = phase;
    if (idx_wr) begin
      ptr_d   = idx_val;
      phase_d = PH_RED;
    end else if (accept) begin
      phase_d = phase_next(phase);
      if (phase == PH_BLU) begin
        ptr_d = ptr + PTR_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      phase <= PH_RED;
    end else if (ptr_en) begin
      ptr   <= ptr_d;
      phase <= phase_d;
    end
  end
endmodule

// File: rtl/gamma_chan_ram.sv
`timescale 1ns/1ps
module gamma_chan_ram #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DAT_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DAT_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [DEPTH];
  logic [DAT_W-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rd_d = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= rd_d;
    end
  end
endmodule

// File: rtl/gamma_seq_lut.sv
`timescale 1ns/1ps
module gamma_seq_lut
  import gamma_lut_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             dat_wr,
  input  logic [DAT_W-1:0] dat_val,
  input  logic [2:0]       wr_mask,
  input  logic             lut_pwr_on,
  input  logic             pix_vld,
  input  logic [IDX_W-1:0] pix_r,
  input  logic [IDX_W-1:0] pix_g,
  input  logic [IDX_W-1:0] pix_b,
  output logic             out_vld,
  output logic [DAT_W-1:0] out_r,
  output logic [DAT_W-1:0] out_g,
  output logic [DAT_W-1:0] out_b
);
  logic [NCH-1:0]   ch_we;
  logic [IDX_W-1:0] wr_ptr;
  phase_e           wr_phase;
  logic [IDX_W-1:0] pix_idx [NCH];
  logic [DAT_W-1:0] ch_out  [NCH];

  assign pix_idx[0] = pix_r;
  assign pix_idx[1] = pix_g;
  assign pix_idx[2] = pix_b;

  gamma_wr_seq #(.IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .idx_val (idx_val),
    .dat_wr  (dat_wr),
    .pwr_on  (lut_pwr_on),
    .wr_mask (wr_mask),
    .ch_we   (ch_we),
    .ptr     (wr_ptr),
    .phase   (wr_phase)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gamma_chan_ram #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ch_we[c]),
      .waddr (wr_ptr),
      .wdata (dat_val),
      .re    (pix_vld),
      .raddr (pix_idx[c]),
      .rdata (ch_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= pix_vld;
    end
  end

  assign out_r = ch_out[0];
  assign out_g = ch_out[1];
  assign out_b = ch_out[2];
endmodule

// File: rtl/gamma_seq_lut_chk.sv
`timescale 1ns/1ps
module gamma_seq_lut_chk #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DAT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idx_wr,
  input logic [IDX_W-1:0] idx_val,
  input logic             dat_wr,
  input logic             pwr_on,
  input logic             pix_vld,
  input logic             out_vld,
  input logic [DAT_W-1:0] out_r,
  input logic [DAT_W-1:0] out_g,
  input logic [DAT_W-1:0] out_b,
  input logic [IDX_W-1:0] ptr,
  input logic [1:0]       phase
);
  logic take;
  assign take = dat_wr & pwr_on & ~idx_wr;

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> out_vld); // R2
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> !out_vld); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R2
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (ptr == $past(idx_val) && phase == 2'd0)); // R3
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && phase == 2'd0) |=> (phase == 2'd1 && $stable(ptr))); // R4
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && phase == 2'd2 && ptr == '1) |=> (ptr == '0 && phase == 2'd0)); // R5
  AST_PWR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !take) |=> ($stable(ptr) && $stable(phase))); // R7
endmodule

bind gamma_seq_lut gamma_seq_lut_chk #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .idx_wr  (idx_wr),
  .idx_val (idx_val),
  .dat_wr  (dat_wr),
  .pwr_on  (lut_pwr_on),
  .pix_vld (pix_vld),
  .out_vld (out_vld),
  .out_r   (out_r),
  .out_g   (out_g),
  .out_b   (out_b),
  .ptr     (wr_ptr),
  .phase   (wr_phase)
);

// File: tb/gamma_seq_lut_bench.sv
`timescale 1ns/1ps
module gamma_seq_lut_bench;
  logic        clk;
  logic        rst_n;
  logic        idx_wr;
  logic [7:0]  idx_val;
  logic        dat_wr;
  logic [11:0] dat_val;
  logic [2:0]  wr_mask;
  logic        lut_pwr_on;
  logic        pix_vld;
  logic [7:0]  pix_r, pix_g, pix_b;
  logic        out_vld;
  logic [11:0] out_r, out_g, out_b;

  gamma_seq_lut u_gamma_seq_lut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
    .dat_wr(dat_wr), .dat_val(dat_val), .wr_mask(wr_mask),
    .lut_pwr_on(lut_pwr_on), .pix_vld(pix_vld), .pix_r(pix_r),
    .pix_g(pix_g), .pix_b(pix_b), .out_vld(out_vld), .out_r(out_r),
    .out_g(out_g), .out_b(out_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_req = "R10";

  // behavioural reference model
  int tbl [3][256];
  bit kn  [3][256];
  int m_out [3];
  bit m_vld, m_kn;
  int m_ptr, m_ph;

  initial begin
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 256; i++) begin
        kn[c][i] = 0; tbl[c][i] = 0;
      end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_kn = 1; m_ptr = 0; m_ph = 0;
      for (int c = 0; c < 3; c++) m_out[c] = 0;
    end else begin
      if (pix_vld) begin
        m_out[0] = tbl[0][pix_r];
        m_out[1] = tbl[1][pix_g];
        m_out[2] = tbl[2][pix_b];
        m_kn = kn[0][pix_r] && kn[1][pix_g] && kn[2][pix_b];
      end
      m_vld = pix_vld;
      if (idx_wr) begin
        m_ptr = idx_val; m_ph = 0;
      end else if (dat_wr && lut_pwr_on) begin
        if (wr_mask[m_ph]) begin
          tbl[m_ph][m_ptr] = dat_val;
          kn[m_ph][m_ptr]  = 1;
        end
        m_ph = m_ph + 1;
        if (m_ph == 3) begin
          m_ph = 0; m_ptr = (m_ptr + 1) % 256;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_vld === m_vld, "out_vld", int'(out_vld), int'(m_vld));
      if (m_kn) begin
        chk(out_r === 12'(m_out[0]), "out_r", int'(out_r), m_out[0]);
        chk(out_g === 12'(m_out[1]), "out_g", int'(out_g), m_out[1]);
        chk(out_b === 12'(m_out[2]), "out_b", int'(out_b), m_out[2]);
      end
    end
  end

  task automatic t_idx(input int v);
    idx_wr = 1; idx_val = 8'(v);
    @(negedge clk);
    idx_wr = 0;
  endtask

  task automatic t_dat(input int v);
    dat_wr = 1; dat_val = 12'(v);
    @(negedge clk);
    dat_wr = 0;
  endtask

  task automatic t_look(input int r, input int g, input int b);
    pix_vld = 1; pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
    @(negedge clk);
    pix_vld = 0;
  endtask

  function automatic int fv(input int i, input int c);
    return (i * 13 + c * 1111 + 7) & 12'hfff;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; idx_wr = 0; idx_val = 0; dat_wr = 0; dat_val = 0;
    wr_mask = 3'b111; lut_pwr_on = 1; pix_vld = 0;
    pix_r = 0; pix_g = 0; pix_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state on the outputs
    cur_req = "R10";
    chk(out_vld === 1'b0, "reset out_vld", int'(out_vld), 0);
    chk(out_r === 12'd0 && out_g === 12'd0 && out_b === 12'd0,
        "reset out_r", int'(out_r), 0);
    // R10: pointer starts at entry 0, rotation at red
    t_dat(12'h111); t_dat(12'h222); t_dat(12'h333);
    t_look(0, 0, 0);
    chk(kn[0][0] && kn[2][0], "reset pointer", m_ptr, 1);

    // R1 / R4: full load from entry 0, then lookups of varied triplets
    cur_req = "R4";
    t_idx(0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) t_dat(fv(i, c));
    cur_req = "R1";
    t_look(0, 0, 0);
    t_look(255, 255, 255);
    t_look(17, 128, 200);
    t_look(3, 99, 254);
    // R2: gaps between lookups, outputs must hold
    cur_req = "R2";
    repeat (3) @(negedge clk);
    t_look(50, 51, 52);
    t_look(60, 61, 62);
    repeat (2) @(negedge clk);

    // R6: only green stored at entry 10
    cur_req = "R6";
    wr_mask = 3'b010;
    t_idx(10);
    t_dat(12'hA01); t_dat(12'hA02); t_dat(12'hA03);
    wr_mask = 3'b111;
    t_look(10, 10, 10);
    @(negedge clk);
    chk(out_r === 12'(fv(10, 0)) && out_g === 12'hA02, "mask",
        int'(out_r), fv(10, 0));

    // R7: words with power off are dropped entirely
    cur_req = "R7";
    t_idx(20);
    lut_pwr_on = 0;
    t_dat(12'hB01); t_dat(12'hB02);
    lut_pwr_on = 1;
    t_dat(12'hC01); t_dat(12'hC02); t_dat(12'hC03);
    t_look(20, 20, 20);
    @(negedge clk);
    chk(out_r === 12'hC01, "pwr gate red", int'(out_r), 12'hC01);

    // R5: wrap from 255 to 0
    cur_req = "R5";
    t_idx(255);
    for (int k = 0; k < 6; k++) t_dat(12'hD00 + k);
    t_look(255, 0, 0);
    @(negedge clk);
    chk(out_g === 12'hD04, "wrap green@0", int'(out_g), 12'hD04);

    // R8: pointer write wins over a simultaneous data word
    cur_req = "R8";
    idx_wr = 1; idx_val = 40; dat_wr = 1; dat_val = 12'hEEE;
    @(negedge clk);
    idx_wr = 0; dat_wr = 0;
    t_dat(12'hE01); t_dat(12'hE02); t_dat(12'hE03);
    t_look(40, 40, 40);

    // R3: pointer write mid-entry returns rotation to red
    cur_req = "R3";
    t_idx(50);
    t_dat(12'hF01);
    t_idx(60);
    t_dat(12'hF11); t_dat(12'hF12); t_dat(12'hF13);
    t_look(50, 50, 50);
    t_look(60, 60, 60);
    @(negedge clk);
    chk(out_r === 12'hF11 && out_g === 12'hF12, "phase reset", int'(out_r), 12'hF11);

    // R9: same-cycle lookup sees the old blue value of entry 70
    cur_req = "R9";
    t_idx(70);
    t_dat(12'h701); t_dat(12'h702);
    dat_wr = 1; dat_val = 12'h703;
    pix_vld = 1; pix_r = 70; pix_g = 70; pix_b = 70;
    @(negedge clk);
    dat_wr = 0; pix_vld = 0;
    chk(out_b === 12'(fv(70, 2)), "read old", int'(out_b), fv(70, 2));
    t_look(70, 70, 70);
    @(negedge clk);
    chk(out_b === 12'h703, "read new", int'(out_b), 12'h703);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule